// File: doc/BRIEF.md
# Linked-Descriptor Transfer Sequencer

This block turns channel triggers into transfer requests for a downstream data mover. It keeps a small register file of transfer descriptor slots. Event channel `i` owns slot `i`. The slots above the channel range are used only as reload sources. A channel can be triggered by a hardware event line, by a software set strobe, or by the completion of an earlier transfer (chaining). Triggers are latched per channel. The block serves one channel at a time, lowest channel number first.

On each trigger the block reads the channel's slot and presents a single request on a valid/ready handshake. The request carries the source and destination addresses, the bytes per array, the number of arrays and the array strides. When the request is accepted, the block advances the addresses and counts and writes them back to the slot. Three counts are walked: bytes per array, arrays per frame, and frames. In array-sync mode each trigger moves one array. In frame-sync mode each trigger moves a whole frame. On the last transfer the slot is reloaded from the slot named in its link field. If the link is the no-link value, the slot is left null instead.

Each accepted request produces a one-cycle completion pulse carrying a 6-bit code. An interrupt pulse and a chain pulse go with it, each qualified by its own option bit. A chain pulse whose code names a valid channel re-triggers that channel. Software loads descriptors through a write port and can read any slot back through a read port.

Top module: `desc_xfer_seq`

## Requirements
- R1: A slot is a 240-bit word. From the most significant end it holds: options [239:208], source [207:176], destination [175:144], link [143:128], bytes per array [127:112], arrays per frame [111:96], frames [95:80], array-count reload [79:64], source array stride [63:48], destination array stride [47:32], source frame stride [31:16] and destination frame stride [15:0]. All strides are signed. A `cfg_we` write stores `cfg_wdata` at slot `cfg_addr`. `rd_data` always shows slot `rd_addr`. Reset clears every slot to zero.
- R2: A one-cycle high on `hw_evt[i]` or `sw_set[i]` triggers channel `i`, which uses slot `i`. The request shows the channel on `req_ch`.
- R3: At most one request is outstanding at a time. When several channels are pending, the lowest-numbered one is served first.
- R4: The request fields come from the channel's slot: `req_src` and `req_dst` are the current addresses, and `req_acnt` is the bytes per array. `req_narr` is 1 in array-sync mode (options bit 2 = 0) and the arrays-per-frame count in frame-sync mode (bit 2 = 1). `req_sstride` and `req_dstride` are the array strides. All request outputs hold steady while `req_valid` is high and `req_ready` is low.
- R5: In array-sync mode an accepted request that is not the last one is written back as follows. If arrays-per-frame is above 1, the array strides are added to the addresses and arrays-per-frame is decremented. If arrays-per-frame equals 1, the frame strides are added to the addresses instead, arrays-per-frame is set to the reload value, and frames is decremented.
- R6: In frame-sync mode an accepted request that is not the last one adds the frame strides to the addresses and decrements frames.
- R7: A request is the last one when frames equals 1 and, in array-sync mode, arrays-per-frame also equals 1. On the last request with a link other than 16'hFFFF, the channel slot is overwritten with the slot given by the link's low address bits.
- R8: On the last request with link 16'hFFFF, the addresses advance as in R5/R6 and all three counts are written as zero. A trigger on a slot with any zero count issues no request. Instead, `err_pulse` rises for one cycle with the channel on `err_ch`.
- R9: In the cycle after each accepted request, `cmp_pulse` is high for exactly one cycle, and `cmp_code` carries options bits [17:12].
- R10: `irq_pulse` goes with `cmp_pulse` when options bit 20 is set on a last request, or when bit 21 is set on any other request.
- R11: `chain_pulse` goes with `cmp_pulse` when options bit 22 is set on a last request, or when bit 23 is set on any other request. If `cmp_code` is below NCH, it also triggers that channel. Otherwise it triggers nothing.
- R12: A trigger that arrives while its channel is pending or in flight is held and not lost. Repeated triggers on a channel that is already pending merge into one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | SLW | Slot written |
| cfg_wdata | input | 240 | Descriptor written |
| rd_addr | input | SLW | Slot read back |
| rd_data | output | 240 | Contents of slot `rd_addr` |
| hw_evt | input | NCH | Hardware event triggers |
| sw_set | input | NCH | Software set triggers |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted by the data mover |
| req_ch | output | CHW | Channel of the request |
| req_src | output | 32 | Source address |
| req_dst | output | 32 | Destination address |
| req_acnt | output | 16 | Bytes per array |
| req_narr | output | 16 | Arrays in this request |
| req_sstride | output | 16 | Source array stride |
| req_dstride | output | 16 | Destination array stride |
| cmp_pulse | output | 1 | Transfer completion pulse |
| cmp_code | output | 6 | Completion code |
| irq_pulse | output | 1 | Qualified interrupt pulse |
| chain_pulse | output | 1 | Qualified chain pulse |
| err_pulse | output | 1 | Trigger on a null slot |
| err_ch | output | CHW | Channel that raised the error |

## Verification
A wrong address or count update does not appear on the request of the transfer that caused it. It appears on the next request from that channel, one trigger later. For that reason the slot is also read back right after every acceptance, so a bad writeback is caught in the cycle after it happens. A broken last-request test shows up as a missing reload, or as an error pulse where a request was expected. A broken pending register or arbiter shows up as a wrong `req_ch`, as a lost request, or as a duplicate request after merged triggers. Wrong qualification of the interrupt or chain pulse is visible in the same cycle as `cmp_pulse`. A faulty chain also brings an unexpected request a few cycles later.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int DESC_W = 240;
  localparam logic [15:0] NO_LINK = 16'hFFFF;

  typedef struct packed {
    logic [31:0] opt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] link;
    logic [15:0] acnt;
    logic [15:0] bcnt;
    logic [15:0] ccnt;
    logic [15:0] brld;
    logic [15:0] sas;
    logic [15:0] das;
    logic [15:0] sfs;
    logic [15:0] dfs;
  } desc_t;

  // option bit positions that change behaviour
  localparam int OPT_FSYNC  = 2;
  localparam int OPT_CODE   = 12;
  localparam int OPT_IRQ_F  = 20;
  localparam int OPT_IRQ_I  = 21;
  localparam int OPT_CHN_F  = 22;
  localparam int OPT_CHN_I  = 23;

  function automatic logic [31:0] add_stride(input logic [31:0] a, input logic [15:0] s);
    return a + {{16{s[15]}}, s};
  endfunction

  function automatic logic is_null(input desc_t d);
    return (d.acnt == 16'd0) || (d.bcnt == 16'd0) || (d.ccnt == 16'd0);
  endfunction

  function automatic logic is_fsync(input desc_t d);
    return d.opt[OPT_FSYNC];
  endfunction

  function automatic logic is_last(input desc_t d);
    if (is_fsync(d)) return d.ccnt == 16'd1;
    return (d.ccnt == 16'd1) && (d.bcnt == 16'd1);
  endfunction

  function automatic logic [15:0] arrays_of(input desc_t d);
    return is_fsync(d) ? d.bcnt : 16'd1;
  endfunction

  function automatic logic [5:0] code_of(input desc_t d);
    return d.opt[OPT_CODE +: 6];
  endfunction

  // address and count update after one accepted request
  function automatic desc_t advance(input desc_t d);
    desc_t n;
    n = d;
    if (!is_fsync(d) && d.bcnt != 16'd1) begin
      n.src  = add_stride(d.src, d.sas);
      n.dst  = add_stride(d.dst, d.das);
      n.bcnt = d.bcnt - 16'd1;
    end else begin
      n.src  = add_stride(d.src, d.sfs);
      n.dst  = add_stride(d.dst, d.dfs);
      n.ccnt = d.ccnt - 16'd1;
      if (!is_fsync(d)) n.bcnt = d.brld;
    end
    return n;
  endfunction

  function automatic desc_t nullify(input desc_t d);
    desc_t n;
    n = d;
    n.acnt = '0;
    n.bcnt = '0;
    n.ccnt = '0;
    return n;
  endfunction

endpackage

// File: rtl/dseq_slot_ram.sv
module dseq_slot_ram
  import dseq_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int SLW = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [SLW-1:0] cfg_addr,
  input  desc_t          cfg_wdata,
  input  logic           wb_en,
  input  logic [SLW-1:0] wb_addr,
  input  desc_t          wb_data,
  input  logic [SLW-1:0] ra_sw,
  output desc_t          rd_sw,
  input  logic [SLW-1:0] ra_grant,
  output desc_t          rd_grant,
  input  logic [SLW-1:0] ra_link,
  output desc_t          rd_link
);

  desc_t mem [NSLOT];

  // writeback is written after the software port, so it wins on the same slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
    end else begin
      if (cfg_we) mem[cfg_addr] <= cfg_wdata;
      if (wb_en)  mem[wb_addr]  <= wb_data;
    end
  end

  assign rd_sw    = mem[ra_sw];
  assign rd_grant = mem[ra_grant];
  assign rd_link  = mem[ra_link];

endmodule

// File: rtl/dseq_trig_arb.sv
module dseq_trig_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_evt,
  input  logic [NCH-1:0] sw_set,
  input  logic [NCH-1:0] chain_set,
  input  logic           take,
  output logic [NCH-1:0] pend_q,
  output logic           grant_valid,
  output logic [CHW-1:0] grant_ch
);

  for (genvar g = 0; g < NCH; g++) begin : g_pend
    logic served;
    assign served = take && (grant_ch == CHW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= (pend_q[g] && !served) || hw_evt[g] || sw_set[g] || chain_set[g];
    end
  end

  always_comb begin
    grant_valid = |pend_q;
    grant_ch    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) grant_ch = CHW'(i);
    end
  end

endmodule

// File: rtl/dseq_engine.sv
module dseq_engine
  import dseq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NSLOT = 16,
  localparam int CHW = $clog2(NCH),
  localparam int SLW = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant_valid,
  input  logic [CHW-1:0] grant_ch,
  input  desc_t          grant_desc,
  output logic           take,
  output logic [SLW-1:0] link_addr,
  input  desc_t          link_desc,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [CHW-1:0] req_ch,
  output logic [31:0]    req_src,
  output logic [31:0]    req_dst,
  output logic [15:0]    req_acnt,
  output logic [15:0]    req_narr,
  output logic [15:0]    req_sstride,
  output logic [15:0]    req_dstride,
  output logic           wb_en,
  output logic [SLW-1:0] wb_addr,
  output desc_t          wb_data,
  output logic           cmp_pulse,
  output logic [5:0]     cmp_code,
  output logic           irq_pulse,
  output logic           chain_pulse,
  output logic [NCH-1:0] chain_set,
  output logic           err_pulse,
  output logic [CHW-1:0] err_ch
);

  typedef enum logic {ST_IDLE, ST_BUSY} st_t;

  st_t            st_q;
  desc_t          cur_q;
  logic [CHW-1:0] ch_q;
  logic           last_w;
  logic           accept_w;
  logic           chain_w;
  logic [5:0]     code_w;

  assign take      = (st_q == ST_IDLE) && grant_valid;
  assign accept_w  = (st_q == ST_BUSY) && req_ready;
  assign last_w    = is_last(cur_q);
  assign code_w    = code_of(cur_q);
  assign chain_w   = last_w ? cur_q.opt[OPT_CHN_F] : cur_q.opt[OPT_CHN_I];
  assign link_addr = cur_q.link[SLW-1:0];

  assign req_valid   = (st_q == ST_BUSY);
  assign req_ch      = ch_q;
  assign req_src     = cur_q.src;
  assign req_dst     = cur_q.dst;
  assign req_acnt    = cur_q.acnt;
  assign req_narr    = arrays_of(cur_q);
  assign req_sstride = cur_q.sas;
  assign req_dstride = cur_q.das;

  assign wb_en   = accept_w;
  assign wb_addr = SLW'(ch_q);

  always_comb begin
    if (!last_w)                   wb_data = advance(cur_q);
    else if (cur_q.link == NO_LINK) wb_data = nullify(advance(cur_q));
    else                           wb_data = link_desc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      ch_q        <= '0;
      cmp_pulse   <= 1'b0;
      cmp_code    <= '0;
      irq_pulse   <= 1'b0;
      chain_pulse <= 1'b0;
      chain_set   <= '0;
      err_pulse   <= 1'b0;
      err_ch      <= '0;
    end else begin
      cmp_pulse   <= 1'b0;
      irq_pulse   <= 1'b0;
      chain_pulse <= 1'b0;
      chain_set   <= '0;
      err_pulse   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (grant_valid) begin
            if (is_null(grant_desc)) begin
              err_pulse <= 1'b1;
              err_ch    <= grant_ch;
            end else begin
              cur_q <= grant_desc;
              ch_q  <= grant_ch;
              st_q  <= ST_BUSY;
            end
          end
        end
        default: begin
          if (req_ready) begin
            st_q        <= ST_IDLE;
            cmp_pulse   <= 1'b1;
            cmp_code    <= code_w;
            irq_pulse   <= last_w ? cur_q.opt[OPT_IRQ_F] : cur_q.opt[OPT_IRQ_I];
            chain_pulse <= chain_w;
            if (chain_w && (int'(code_w) < NCH)) chain_set[code_w[CHW-1:0]] <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/desc_xfer_seq.sv
module desc_xfer_seq
  import dseq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int NSLOT = 16,
  localparam int CHW = $clog2(NCH),
  localparam int SLW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLW-1:0]    cfg_addr,
  input  logic [DESC_W-1:0] cfg_wdata,
  input  logic [SLW-1:0]    rd_addr,
  output logic [DESC_W-1:0] rd_data,
  input  logic [NCH-1:0]    hw_evt,
  input  logic [NCH-1:0]    sw_set,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CHW-1:0]    req_ch,
  output logic [31:0]       req_src,
  output logic [31:0]       req_dst,
  output logic [15:0]       req_acnt,
  output logic [15:0]       req_narr,
  output logic [15:0]       req_sstride,
  output logic [15:0]       req_dstride,
  output logic              cmp_pulse,
  output logic [5:0]        cmp_code,
  output logic              irq_pulse,
  output logic              chain_pulse,
  output logic              err_pulse,
  output logic [CHW-1:0]    err_ch
);

  // named internal events, also observed by the bound checker
  logic [NCH-1:0] pend_q;
  logic           grant_valid;
  logic [CHW-1:0] grant_ch;
  logic           take;
  logic           wb_en;
  logic [SLW-1:0] wb_addr;
  desc_t          wb_data;
  logic [NCH-1:0] chain_set;
  logic [SLW-1:0] link_addr;
  desc_t          grant_desc;
  desc_t          link_desc;
  desc_t          sw_desc;

  dseq_slot_ram #(.NSLOT(NSLOT)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(desc_t'(cfg_wdata)),
    .wb_en    (wb_en),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .ra_sw    (rd_addr),
    .rd_sw    (sw_desc),
    .ra_grant (SLW'(grant_ch)),
    .rd_grant (grant_desc),
    .ra_link  (link_addr),
    .rd_link  (link_desc)
  );

  assign rd_data = sw_desc;

  dseq_trig_arb #(.NCH(NCH)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_evt     (hw_evt),
    .sw_set     (sw_set),
    .chain_set  (chain_set),
    .take       (take),
    .pend_q     (pend_q),
    .grant_valid(grant_valid),
    .grant_ch   (grant_ch)
  );

  dseq_engine #(.NCH(NCH), .NSLOT(NSLOT)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_valid(grant_valid),
    .grant_ch   (grant_ch),
    .grant_desc (grant_desc),
    .take       (take),
    .link_addr  (link_addr),
    .link_desc  (link_desc),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_ch     (req_ch),
    .req_src    (req_src),
    .req_dst    (req_dst),
    .req_acnt   (req_acnt),
    .req_narr   (req_narr),
    .req_sstride(req_sstride),
    .req_dstride(req_dstride),
    .wb_en      (wb_en),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .cmp_pulse  (cmp_pulse),
    .cmp_code   (cmp_code),
    .irq_pulse  (irq_pulse),
    .chain_pulse(chain_pulse),
    .chain_set  (chain_set),
    .err_pulse  (err_pulse),
    .err_ch     (err_ch)
  );

endmodule

// File: rtl/desc_xfer_seq_chk.sv
module desc_xfer_seq_chk #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CHW-1:0] req_ch,
  input logic [31:0]    req_src,
  input logic [31:0]    req_dst,
  input logic [15:0]    req_acnt,
  input logic [15:0]    req_narr,
  input logic           cmp_pulse,
  input logic           irq_pulse,
  input logic           chain_pulse,
  input logic           err_pulse,
  input logic [NCH-1:0] pend_q,
  input logic           grant_valid,
  input logic [CHW-1:0] grant_ch,
  input logic           take,
  input logic           wb_en
);

  logic [NCH-1:0] below;
  always_comb below = (NCH'(1) << grant_ch) - NCH'(1);

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (pend_q[grant_ch] && ((pend_q & below) == '0))); // R3
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !take); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_dst)
      && $stable(req_acnt) && $stable(req_narr) && $stable(req_ch))); // R4
  AST_WB_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (req_valid && req_ready)); // R7
  AST_NONNULL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_acnt != 16'd0 && req_narr != 16'd0)); // R8
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !req_valid); // R8
  AST_CMP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmp_pulse); // R9
  AST_CMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse); // R9
  AST_IRQ_WITH_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> cmp_pulse); // R10
  AST_CHAIN_WITH_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    chain_pulse |-> cmp_pulse); // R11

endmodule

bind desc_xfer_seq desc_xfer_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/test_desc_xfer_seq.sv
module test_desc_xfer_seq;
  localparam int NCH = 4;
  localparam int NSLOT = 16;
  localparam int W = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [3:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [NCH-1:0] hw_evt = '0, sw_set = '0;
  logic req_valid, req_ready = 1'b0;
  logic [1:0] req_ch;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_acnt, req_narr, req_sstride, req_dstride;
  logic cmp_pulse, irq_pulse, chain_pulse, err_pulse;
  logic [5:0] cmp_code;
  logic [1:0] err_ch;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [W-1:0] mdl [NSLOT];

  always #5 clk = ~clk;

  desc_xfer_seq #(.NCH(NCH), .NSLOT(NSLOT)) i_desc_xfer_seq (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(input logic [31:0] opt, src, dst, input logic [15:0] lnk,
      acnt, bcnt, ccnt, brld, sas, das, sfs, dfs);
    return {opt, src, dst, lnk, acnt, bcnt, ccnt, brld, sas, das, sfs, dfs};
  endfunction

  // bench view of the rules: R5..R8
  function automatic logic b_last(input logic [W-1:0] d);
    return (d[95:80] == 1) && (d[210] || d[111:96] == 1);
  endfunction

  function automatic logic [W-1:0] b_step(input logic [W-1:0] d, input logic [W-1:0] lk);
    logic [W-1:0] n;
    logic frame_edge;
    n = d;
    frame_edge = d[210] || (d[111:96] == 1);
    if (frame_edge) begin
      n[207:176] = d[207:176] + 32'($signed(d[31:16]));
      n[175:144] = d[175:144] + 32'($signed(d[15:0]));
      n[95:80]   = d[95:80] - 1;
      if (!d[210]) n[111:96] = d[79:64];
    end else begin
      n[207:176] = d[207:176] + 32'($signed(d[63:48]));
      n[175:144] = d[175:144] + 32'($signed(d[47:32]));
      n[111:96]  = d[111:96] - 1;
    end
    if (b_last(d)) begin
      if (d[143:128] == 16'hFFFF) n[127:80] = '0;
      else n = lk;
    end
    return n;
  endfunction

  task automatic wr(input int idx, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mdl[idx] = d;
  endtask

  task automatic trig(input int ch, input bit via_sw);
    @(negedge clk);
    if (via_sw) sw_set[ch] = 1; else hw_evt[ch] = 1;
    @(negedge clk);
    sw_set = '0; hw_evt = '0;
  endtask

  task automatic serve(input int ch, input int dly);
    logic [W-1:0] d, n;
    logic lst;
    int w;
    string tg;
    d = mdl[ch];
    w = 0;
    while (!req_valid && w < 40) begin @(negedge clk); w++; end
    if (!req_valid) begin chk("R3 request expected", 0, 1); return; end
    chk("R2 req_ch", req_ch, ch);
    chk("R4 req_src", req_src, d[207:176]);
    chk("R4 req_dst", req_dst, d[175:144]);
    chk("R4 req_acnt", req_acnt, d[127:112]);
    chk("R4 req_narr", req_narr, d[210] ? d[111:96] : 16'd1);
    chk("R4 req_sstride", req_sstride, d[63:48]);
    repeat (dly) @(negedge clk);
    if (dly > 0) chk("R4 held src", req_src, d[207:176]);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    lst = b_last(d);
    chk("R9 cmp_pulse", cmp_pulse, 1);
    chk("R9 cmp_code", cmp_code, d[225:220]);
    chk("R10 irq_pulse", irq_pulse, lst ? d[228] : d[229]);
    chk("R11 chain_pulse", chain_pulse, lst ? d[230] : d[231]);
    n = b_step(d, mdl[d[131:128]]);
    mdl[ch] = n;
    rd_addr = 4'(ch);
    #1;
    tg = lst ? (d[143:128] == 16'hFFFF ? "R8 null writeback" : "R7 link reload")
             : (d[210] ? "R6 frame writeback" : "R5 array writeback");
    chk(tg, rd_data, n);
    @(negedge clk);
    chk("R9 single cycle", cmp_pulse, 0);
  endtask

  task automatic expect_err(input int ch);
    bit seen = 0;
    bit rq = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_valid) rq = 1;
      if (err_pulse && !seen) begin seen = 1; chk("R8 err_ch", err_ch, ch); end
    end
    chk("R8 err_pulse", seen, 1);
    chk("R8 no request on null", rq, 0);
  endtask

  task automatic expect_idle(input string tag, input int n);
    bit rq = 0;
    repeat (n) begin @(negedge clk); if (req_valid) rq = 1; end
    chk(tag, rq, 0);
  endtask

  function automatic logic [W-1:0] rnd_desc();
    logic [31:0] opt;
    logic [15:0] b, lk;
    opt = $urandom & 32'h0033_F704;   // sync, code, irq enables; chain bits off
    b = 16'($urandom_range(1, 3));
    lk = ($urandom_range(0, 2) == 0) ? 16'hFFFF : 16'($urandom_range(NCH, NSLOT - 1));
    return mk(opt, $urandom, $urandom, lk, 16'($urandom_range(1, 255)), b,
              16'($urandom_range(1, 3)), b, 16'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd20240611);
    for (int i = 0; i < NSLOT; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset req_valid", req_valid, 0);
    chk("R9 reset cmp_pulse", cmp_pulse, 0);
    rd_addr = 4'd5; #1;
    chk("R1 reset slot", rd_data, '0);

    // array-sync walk with reload into a frame-sync link slot
    wr(8, mk(32'h0010_0004 | (32'd7 << 12), 32'h100, 32'h200, 16'hFFFF, 4, 3, 1, 3, 4, 8, 0, 0));
    wr(0, mk(32'h0030_0000 | (32'd5 << 12), 32'h1000, 32'h2000, 16'd8, 16, 2, 2, 2,
             16, 32, -16'sd8, 16'd100));
    rd_addr = 4'd0; #1;
    chk("R1 readback", rd_data, mdl[0]);
    for (int k = 0; k < 4; k++) begin trig(0, k[0]); serve(0, k); end
    trig(0, 1); serve(0, 0);
    trig(0, 0); expect_err(0);

    // chaining: ch1 final chain to ch2, ch2 chains to code 9 (no channel)
    wr(1, mk(32'h0040_0000 | (32'd2 << 12), 32'h10, 32'h20, 16'hFFFF, 8, 1, 1, 1, 0, 0, 0, 0));
    wr(2, mk(32'h0040_0000 | (32'd9 << 12), 32'h30, 32'h40, 16'hFFFF, 8, 1, 1, 1, 0, 0, 0, 0));
    trig(1, 0); serve(1, 0); serve(2, 1);
    expect_idle("R11 out-of-range code triggers nothing", 12);

    // priority: three channels pending together
    wr(1, mk(32'h0, 32'h1, 32'h2, 16'hFFFF, 2, 3, 3, 3, 1, 1, 1, 1));
    wr(2, mk(32'h4, 32'h3, 32'h4, 16'hFFFF, 2, 3, 3, 3, 1, 1, 1, 1));
    wr(3, mk(32'h0, 32'h5, 32'h6, 16'hFFFF, 2, 3, 3, 3, 1, 1, 1, 1));
    @(negedge clk); hw_evt[3] = 1; sw_set[1] = 1; hw_evt[2] = 1;
    @(negedge clk); hw_evt = '0; sw_set = '0;
    serve(1, 0); serve(2, 0); serve(3, 0);

    // triggers while busy are held and merged
    wr(0, mk(32'h0, 32'h7, 32'h8, 16'hFFFF, 2, 4, 4, 4, 1, 1, 1, 1));
    trig(1, 0);
    while (!req_valid) @(negedge clk);
    trig(1, 1); trig(1, 0); trig(0, 0);
    serve(1, 0); serve(0, 0); serve(1, 0);
    expect_idle("R12 merged triggers give one request", 10);

    // random traffic
    for (int s = NCH; s < NSLOT; s++) wr(s, rnd_desc());
    for (int it = 0; it < 200; it++) begin
      int ch;
      ch = $urandom_range(0, NCH - 1);
      if ((mdl[ch][127:112] == 0 || mdl[ch][111:96] == 0 || mdl[ch][95:80] == 0)
          && $urandom_range(0, 3) != 0) wr(ch, rnd_desc());
      trig(ch, $urandom_range(0, 1) == 1);
      if (mdl[ch][127:112] == 0 || mdl[ch][111:96] == 0 || mdl[ch][95:80] == 0) expect_err(ch);
      else serve(ch, $urandom_range(0, 3));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule